// File: doc/BRIEF.md
# Ethernet Power-Management Register Unit

This block keeps the power-down control, the two wake-source enables and the magic-packet status flag for an Ethernet MAC. It also keeps a bank of wake-up frame filter words that the pattern matcher reads. Software reaches everything through a small register bus with address, write strobe, read strobe, write data and read data. The receive path reports a detected magic packet and a matched wake-up frame as one-cycle pulses. While the link is powered down, the unit gates off every received frame.

The filter words have no address each. They sit behind one shared offset, and an internal pointer moves on by one word on every read or write at that offset. It returns to word 0 after the last word, so a run of back-to-back accesses loads or dumps the whole bank. Software can set the power-down bit but cannot clear it. Only an enabled wake event clears it. The magic-packet status flag clears when software reads the control register.

Read data is combinational from the current state by default, with an optional registered variant. A read therefore shows the state from before that cycle's update.

Top module: `eth_pm_regs`

## Requirements
- R1: After reset, the control register reads 0x00000000, every filter word is zero, the filter pointer is at word 0 and `pm_event` is low.
- R2: The control register is at offset 0x2C. Bit 0 is power-down, bit 1 is magic-packet enable, bit 2 is wake-frame enable and bit 5 is magic-packet-received. All other bits read as 0. A write loads bits 1 and 2 directly.
- R3: A control write with bit 0 = 1 sets power-down only if bit 1 or bit 2 of that same write data is 1. A write with bit 0 = 0 never clears power-down.
- R4: While power-down is 1, `rx_frm_fwd` is 0 and `rx_drop` equals `rx_frm_vld`. While power-down is 0, `rx_frm_fwd` equals `rx_frm_vld` and `rx_drop` is 0.
- R5: A `magic_det` pulse while magic-packet enable is 1 clears power-down, sets magic-packet-received and drives `pm_event` high for exactly the following cycle.
- R6: A `wake_frm_hit` pulse while wake-frame enable is 1 clears power-down and drives `pm_event` high for the following cycle. It leaves magic-packet-received unchanged.
- R7: A wake pulse whose enable is 0 changes neither power-down nor magic-packet-received, and `pm_event` stays low.
- R8: Reading the control register clears magic-packet-received after returning it. Software writes to bit 5 have no effect.
- R9: When an enabled magic packet and a control read fall in the same cycle, the read returns the old flag value and the flag ends up set.
- R10: Each write at offset 0x28 stores the data in the word at the pointer. Each read at offset 0x28 returns that word. Either access advances the pointer by one, and the pointer wraps from the last word to word 0.
- R11: `filt_words` presents word k of the filter bank on bits [k*DATA_W +: DATA_W] at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data |
| magic_det | input | 1 | Magic packet detected, one-cycle pulse |
| wake_frm_hit | input | 1 | Wake-up frame matched, one-cycle pulse |
| rx_frm_vld | input | 1 | Receive frame valid |
| rx_frm_fwd | output | 1 | Frame passed on to the application |
| rx_drop | output | 1 | Valid frame discarded while powered down |
| pm_event | output | 1 | Power-management event pulse |
| filt_words | output | NUM_FILT*DATA_W | Flattened filter bank for the matcher |

## Verification
The bench builds the block with its defaults: 8-bit offsets, 32-bit data, eight filter words and combinational read data. With eight words, two full laps of the pointer take only sixteen accesses, so the wrap and the mixed read/write walk are covered completely.

The six low control bits are swept through all 64 write values, each followed by a readback and a return to the idle state. All sixteen combinations of the two enables and the two wake pulses are also applied with power-down armed. That reaches every gating case, including the disabled events that must leave state alone and the collision of a status read with a new magic packet.

// File: rtl/eth_pm_pkg.sv
package eth_pm_pkg;
   // Bit positions inside the control/status word
   localparam int unsigned PM_PD_BIT  = 0;
   localparam int unsigned PM_MPE_BIT = 1;
   localparam int unsigned PM_WFE_BIT = 2;
   localparam int unsigned PM_MPR_BIT = 5;
   localparam int unsigned PM_CSR_USED = 6;

   typedef struct packed {
      logic mpr;   // magic packet received (status)
      logic wfe;   // wake frame enable
      logic mpe;   // magic packet enable
      logic pd;    // power-down
   } pm_ctl_t;

   function automatic logic [PM_CSR_USED-1:0] pm_pack(input pm_ctl_t c);
      logic [PM_CSR_USED-1:0] v;
      v = '0;
      v[PM_PD_BIT]  = c.pd;
      v[PM_MPE_BIT] = c.mpe;
      v[PM_WFE_BIT] = c.wfe;
      v[PM_MPR_BIT] = c.mpr;
      return v;
   endfunction
endpackage

// File: rtl/eth_pm_filt_bank.sv
module eth_pm_filt_bank #(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned NUM_FILT = 8,
   localparam int unsigned PTR_W   = (NUM_FILT > 1) ? $clog2(NUM_FILT) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       acc_wr,
   input  logic                       acc_rd,
   input  logic [DATA_W-1:0]          wdata,
   output logic [DATA_W-1:0]          rd_word,
   output logic [PTR_W-1:0]           ptr_o,
   output logic [NUM_FILT*DATA_W-1:0] words_flat
);
   localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_FILT - 1);

   logic [PTR_W-1:0]  ptr_q;
   logic [DATA_W-1:0] mem_q [NUM_FILT];
   logic              step;

   assign step = acc_wr | acc_rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (step) begin
         if (ptr_q == LAST) ptr_q <= '0;
         else               ptr_q <= ptr_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_FILT; i++) mem_q[i] <= '0;
      end else if (acc_wr) begin
         for (int i = 0; i < NUM_FILT; i++) begin
            if (ptr_q == PTR_W'(i)) mem_q[i] <= wdata;
         end
      end
   end

   always_comb begin
      rd_word = '0;
      for (int i = 0; i < NUM_FILT; i++) begin
         if (ptr_q == PTR_W'(i)) rd_word = mem_q[i];
      end
   end

   for (genvar g = 0; g < NUM_FILT; g++) begin : g_flat
      assign words_flat[g*DATA_W +: DATA_W] = mem_q[g];
   end

   assign ptr_o = ptr_q;
endmodule

// File: rtl/eth_pm_ctl.sv
module eth_pm_ctl
   import eth_pm_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csr_wr,
   input  logic              csr_rd,
   input  logic [DATA_W-1:0] wdata,
   input  logic              magic_det,
   input  logic              wake_frm_hit,
   output pm_ctl_t           ctl_o,
   output logic              pm_event
);
   pm_ctl_t ctl_q;
   logic    wake_mp, wake_wf, arm_ok;

   assign wake_mp = magic_det & ctl_q.mpe;
   assign wake_wf = wake_frm_hit & ctl_q.wfe;
   assign arm_ok  = wdata[PM_PD_BIT] & (wdata[PM_MPE_BIT] | wdata[PM_WFE_BIT]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q    <= '0;
         pm_event <= 1'b0;
      end else begin
         pm_event <= wake_mp | wake_wf;
         if (csr_wr) begin
            ctl_q.mpe <= wdata[PM_MPE_BIT];
            ctl_q.wfe <= wdata[PM_WFE_BIT];
         end
         // an enabled wake event beats a software arm in the same cycle
         if (wake_mp | wake_wf)  ctl_q.pd <= 1'b0;
         else if (csr_wr & arm_ok) ctl_q.pd <= 1'b1;
         // hardware set beats read-clear
         if (wake_mp)     ctl_q.mpr <= 1'b1;
         else if (csr_rd) ctl_q.mpr <= 1'b0;
      end
   end

   assign ctl_o = ctl_q;
endmodule

// File: rtl/eth_pm_rx_gate.sv
module eth_pm_rx_gate (
   input  logic pd,
   input  logic rx_frm_vld,
   output logic rx_frm_fwd,
   output logic rx_drop
);
   assign rx_frm_fwd = rx_frm_vld & ~pd;
   assign rx_drop    = rx_frm_vld & pd;
endmodule

// File: rtl/eth_pm_regs.sv
module eth_pm_regs
   import eth_pm_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned NUM_FILT = 8,
   parameter int unsigned FILT_OFS = 'h28,
   parameter int unsigned CSR_OFS  = 'h2C,
   parameter int unsigned RD_LAT   = 0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [ADDR_W-1:0]          reg_addr,
   input  logic                       reg_wr,
   input  logic                       reg_rd,
   input  logic [DATA_W-1:0]          reg_wdata,
   output logic [DATA_W-1:0]          reg_rdata,
   input  logic                       magic_det,
   input  logic                       wake_frm_hit,
   input  logic                       rx_frm_vld,
   output logic                       rx_frm_fwd,
   output logic                       rx_drop,
   output logic                       pm_event,
   output logic [NUM_FILT*DATA_W-1:0] filt_words
);
   localparam int unsigned PTR_W = (NUM_FILT > 1) ? $clog2(NUM_FILT) : 1;

   // elaboration-time parameter checks
   if (NUM_FILT < 2 || (NUM_FILT & (NUM_FILT - 1)) != 0) begin : g_bad_nf
      $error("NUM_FILT must be a power of two of at least 2");
   end
   if (DATA_W < PM_CSR_USED) begin : g_bad_dw
      $error("DATA_W too narrow for the control word");
   end
   if (FILT_OFS == CSR_OFS) begin : g_bad_ofs
      $error("filter and control offsets must differ");
   end
   if (FILT_OFS >= (1 << ADDR_W) || CSR_OFS >= (1 << ADDR_W)) begin : g_bad_aw
      $error("offset does not fit ADDR_W");
   end
   if (RD_LAT > 1) begin : g_bad_lat
      $error("RD_LAT must be 0 or 1");
   end

   logic              hit_filt, hit_csr;
   logic              filt_wr, filt_rd, csr_wr, csr_rd;
   logic [DATA_W-1:0] filt_rd_word, rd_mux;
   logic [PTR_W-1:0]  filt_ptr;
   pm_ctl_t           ctl_q;

   assign hit_filt = (reg_addr == ADDR_W'(FILT_OFS));
   assign hit_csr  = (reg_addr == ADDR_W'(CSR_OFS));
   assign filt_wr  = reg_wr & hit_filt;
   assign filt_rd  = reg_rd & hit_filt;
   assign csr_wr   = reg_wr & hit_csr;
   assign csr_rd   = reg_rd & hit_csr;

   eth_pm_filt_bank #(
      .DATA_W   (DATA_W),
      .NUM_FILT (NUM_FILT)
   ) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .acc_wr     (filt_wr),
      .acc_rd     (filt_rd),
      .wdata      (reg_wdata),
      .rd_word    (filt_rd_word),
      .ptr_o      (filt_ptr),
      .words_flat (filt_words)
   );

   eth_pm_ctl #(
      .DATA_W (DATA_W)
   ) u_ctl (
      .clk          (clk),
      .rst_n        (rst_n),
      .csr_wr       (csr_wr),
      .csr_rd       (csr_rd),
      .wdata        (reg_wdata),
      .magic_det    (magic_det),
      .wake_frm_hit (wake_frm_hit),
      .ctl_o        (ctl_q),
      .pm_event     (pm_event)
   );

   eth_pm_rx_gate u_gate (
      .pd         (ctl_q.pd),
      .rx_frm_vld (rx_frm_vld),
      .rx_frm_fwd (rx_frm_fwd),
      .rx_drop    (rx_drop)
   );

   always_comb begin
      rd_mux = '0;
      if (reg_rd) begin
         if (hit_csr)       rd_mux = DATA_W'(pm_pack(ctl_q));
         else if (hit_filt) rd_mux = filt_rd_word;
      end
   end

   if (RD_LAT == 0) begin : g_rd_comb
      assign reg_rdata = rd_mux;
   end else begin : g_rd_reg
      logic [DATA_W-1:0] rd_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rd_q <= '0;
         else        rd_q <= rd_mux;
      end
      assign reg_rdata = rd_q;
   end
endmodule

// File: rtl/eth_pm_regs_chk.sv
module eth_pm_regs_chk
   import eth_pm_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned NUM_FILT = 8,
   parameter int unsigned FILT_OFS = 'h28,
   parameter int unsigned CSR_OFS  = 'h2C,
   localparam int unsigned PTR_W   = (NUM_FILT > 1) ? $clog2(NUM_FILT) : 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              reg_wr,
   input logic              reg_rd,
   input logic [DATA_W-1:0] reg_wdata,
   input logic              magic_det,
   input logic              wake_frm_hit,
   input logic              rx_frm_fwd,
   input logic              pm_event,
   input pm_ctl_t           ctl,
   input logic [PTR_W-1:0]  ptr
);
   logic csr_acc_rd, csr_acc_wr, filt_acc, wm, wf;
   assign csr_acc_rd = reg_rd && reg_addr == ADDR_W'(CSR_OFS);
   assign csr_acc_wr = reg_wr && reg_addr == ADDR_W'(CSR_OFS);
   assign filt_acc   = (reg_rd || reg_wr) && reg_addr == ADDR_W'(FILT_OFS);
   assign wm = magic_det && ctl.mpe;
   assign wf = wake_frm_hit && ctl.wfe;

   p_arm_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_acc_wr && reg_wdata[PM_PD_BIT] && (reg_wdata[PM_MPE_BIT] || reg_wdata[PM_WFE_BIT])
       && !wm && !wf) |=> ctl.pd);
   p_no_disarm_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.pd && !wm && !wf) |=> ctl.pd);
   p_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.pd |-> !rx_frm_fwd);
   p_magic_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wm |=> (ctl.mpr && !ctl.pd && pm_event));
   p_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wf |=> (!ctl.pd && pm_event));
   p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!wm && !wf) |=> !pm_event);
   p_rdclr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_acc_rd && !wm) |=> !ctl.mpr);
   p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_acc_rd && wm) |=> ctl.mpr);
   p_ptr_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (filt_acc && ptr == PTR_W'(NUM_FILT - 1)) |=> ptr == '0);
   p_ptr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !filt_acc |=> $stable(ptr));
endmodule

bind eth_pm_regs eth_pm_regs_chk #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .NUM_FILT (NUM_FILT),
   .FILT_OFS (FILT_OFS),
   .CSR_OFS  (CSR_OFS)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .reg_addr     (reg_addr),
   .reg_wr       (reg_wr),
   .reg_rd       (reg_rd),
   .reg_wdata    (reg_wdata),
   .magic_det    (magic_det),
   .wake_frm_hit (wake_frm_hit),
   .rx_frm_fwd   (rx_frm_fwd),
   .pm_event     (pm_event),
   .ctl          (ctl_q),
   .ptr          (filt_ptr)
);

// File: tb/eth_pm_regs_test.sv
module eth_pm_regs_test;
   localparam int CLK_P = 10;
   localparam int NF    = 8;
   localparam logic [7:0] A_FILT = 8'h28;
   localparam logic [7:0] A_CSR  = 8'h2C;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [7:0]    reg_addr = '0;
   logic          reg_wr = 1'b0, reg_rd = 1'b0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic          magic_det = 1'b0, wake_frm_hit = 1'b0, rx_frm_vld = 1'b0;
   logic          rx_frm_fwd, rx_drop, pm_event;
   logic [NF*32-1:0] filt_words;

   int vectors = 0;
   int fails   = 0;
   bit done    = 1'b0;

   // bench-side model of the requirements
   logic        m_pd = 0, m_mpe = 0, m_wfe = 0, m_mpr = 0;
   logic [31:0] m_w [NF];
   int          m_ptr = 0;

   always #(CLK_P/2) clk = ~clk;

   eth_pm_regs uut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .magic_det(magic_det),
      .wake_frm_hit(wake_frm_hit), .rx_frm_vld(rx_frm_vld), .rx_frm_fwd(rx_frm_fwd),
      .rx_drop(rx_drop), .pm_event(pm_event), .filt_words(filt_words)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step(input logic wr, input logic rd, input logic [7:0] addr,
                       input logic [31:0] wd, input logic mg, input logic wk,
                       input logic vl, input string tag);
      logic        em, ef;
      logic [31:0] exp_rd;
      logic [NF*32-1:0] exp_flat;
      string       etag;
      @(negedge clk);
      reg_wr = wr; reg_rd = rd; reg_addr = addr; reg_wdata = wd;
      magic_det = mg; wake_frm_hit = wk; rx_frm_vld = vl;
      #1;
      em = mg & m_mpe;
      ef = wk & m_wfe;
      if (rd) begin
         if (addr == A_CSR)       exp_rd = {26'b0, m_mpr, 2'b00, m_wfe, m_mpe, m_pd};
         else if (addr == A_FILT) exp_rd = m_w[m_ptr];
         else                     exp_rd = '0;
         check(tag, reg_rdata, exp_rd);
      end
      check("R4 fwd", {31'b0, rx_frm_fwd}, {31'b0, vl & ~m_pd});
      check("R4 drop", {31'b0, rx_drop}, {31'b0, vl & m_pd});
      // model update
      if (wr && addr == A_CSR) begin
         m_mpe = wd[1];
         m_wfe = wd[2];
      end
      if (em | ef) m_pd = 1'b0;
      else if (wr && addr == A_CSR && wd[0] && (wd[1] | wd[2])) m_pd = 1'b1;
      if (em) m_mpr = 1'b1;
      else if (rd && addr == A_CSR) m_mpr = 1'b0;
      if ((wr || rd) && addr == A_FILT) begin
         if (wr) m_w[m_ptr] = wd;
         m_ptr = (m_ptr + 1) % NF;
      end
      @(posedge clk);
      #1;
      if (em) etag = "R5 event";
      else if (ef) etag = "R6 event";
      else etag = "R7 event";
      check(etag, {31'b0, pm_event}, {31'b0, em | ef});
      for (int i = 0; i < NF; i++) exp_flat[i*32 +: 32] = m_w[i];
      check("R11 filt_words", {31'b0, filt_words == exp_flat}, 32'd1);
   endtask

   task automatic idle(input logic vl);
      step(1'b0, 1'b0, 8'h00, 32'h0, 1'b0, 1'b0, vl, "idle");
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NF; i++) m_w[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      check("R1 pm_event", {31'b0, pm_event}, 32'd0);
      check("R1 filt_words", {31'b0, filt_words == '0}, 32'd1);
      step(1'b0, 1'b1, A_CSR, 32'h0, 1'b0, 1'b0, 1'b1, "R1 csr");
      step(1'b0, 1'b1, A_FILT, 32'h0, 1'b0, 1'b0, 1'b0, "R1 word0");

      // R10: two laps of writes, then reads past the wrap, then mixed
      for (int i = 0; i < 2 * NF; i++)
         step(1'b1, 1'b0, A_FILT, 32'hA5000000 ^ (i * 32'h01030507), 1'b0, 1'b0, 1'b0, "R10 wr");
      for (int i = 0; i < NF + 3; i++)
         step(1'b0, 1'b1, A_FILT, 32'h0, 1'b0, 1'b0, 1'b0, "R10 rd");
      for (int i = 0; i < 2 * NF; i++) begin
         if (i % 3 == 0) step(1'b1, 1'b0, A_FILT, 32'h5A5A0000 + i, 1'b0, 1'b0, 1'b0, "R10 mix wr");
         else            step(1'b0, 1'b1, A_FILT, 32'h0, 1'b0, 1'b0, 1'b0, "R10 mix rd");
      end

      // R2: only bits 1 and 2 are writable
      step(1'b1, 1'b0, A_CSR, 32'hFFFF_FFD8, 1'b0, 1'b0, 1'b0, "R2 wr");
      step(1'b0, 1'b1, A_CSR, 32'h0, 1'b0, 1'b0, 1'b0, "R2 rd zero");
      step(1'b1, 1'b0, A_CSR, 32'hFFFF_FFDE, 1'b0, 1'b0, 1'b0, "R2 wr");
      step(1'b0, 1'b1, A_CSR, 32'h0, 1'b0, 1'b0, 1'b0, "R2 rd en");

      // R3: sweep all 64 low control values, return to idle each time
      for (int v = 0; v < 64; v++) begin
         step(1'b1, 1'b0, A_CSR, 32'(v), 1'b0, 1'b0, 1'b1, "R3 wr");
         step(1'b0, 1'b1, A_CSR, 32'h0, 1'b0, 1'b0, 1'b1, "R3 rd");
         step(1'b1, 1'b0, A_CSR, 32'h0000_0002, 1'b0, 1'b0, 1'b1, "R3 wr0");
         step(1'b0, 1'b1, A_CSR, 32'h0, 1'b0, 1'b0, 1'b0, "R3 hold");
         step(1'b0, 1'b0, 8'h00, 32'h0, 1'b1, 1'b0, 1'b1, "R5 clear");
         step(1'b0, 1'b1, A_CSR, 32'h0, 1'b0, 1'b0, 1'b0, "R8 rdclr");
      end

      // R5/R6/R7: every enable and pulse combination with power-down armed
      for (int c = 0; c < 16; c++) begin
         step(1'b1, 1'b0, A_CSR, {29'b0, c[1], c[0], 1'b1}, 1'b0, 1'b0, 1'b1, "R3 arm");
         step(1'b0, 1'b0, 8'h00, 32'h0, c[2], c[3], 1'b1, "R5 R6 R7 pulse");
         idle(1'b1);
         step(1'b0, 1'b1, A_CSR, 32'h0, 1'b0, 1'b0, 1'b0, "R7 state");
         step(1'b1, 1'b0, A_CSR, 32'h0000_0006, 1'b0, 1'b0, 1'b0, "R7 en");
         step(1'b0, 1'b0, 8'h00, 32'h0, 1'b1, 1'b0, 1'b0, "R5 clear");
         step(1'b0, 1'b1, A_CSR, 32'h0, 1'b0, 1'b0, 1'b0, "R8 rdclr");
      end

      // R8: writes to bit 5 have no effect
      step(1'b1, 1'b0, A_CSR, 32'h0000_0022, 1'b0, 1'b0, 1'b0, "R8 wr1");
      step(1'b0, 1'b1, A_CSR, 32'h0, 1'b0, 1'b0, 1'b0, "R8 rd0");
      step(1'b0, 1'b0, 8'h00, 32'h0, 1'b1, 1'b0, 1'b0, "R5 set");
      step(1'b1, 1'b0, A_CSR, 32'h0000_0002, 1'b0, 1'b0, 1'b0, "R8 wr0");
      step(1'b0, 1'b1, A_CSR, 32'h0, 1'b0, 1'b0, 1'b0, "R8 rd1");
      step(1'b0, 1'b1, A_CSR, 32'h0, 1'b0, 1'b0, 1'b0, "R8 rd cleared");

      // R9: read and enabled magic packet together
      step(1'b0, 1'b1, A_CSR, 32'h0, 1'b1, 1'b0, 1'b0, "R9 old value");
      step(1'b0, 1'b1, A_CSR, 32'h0, 1'b0, 1'b0, 1'b0, "R9 flag kept");
      step(1'b0, 1'b1, A_CSR, 32'h0, 1'b0, 1'b0, 1'b0, "R9 flag gone");

      idle(1'b0);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule